// File: doc/BRIEF.md
# Hourly Strobe Generator

This block divides a slow time base down to one strobe per hour. A one-cycle-wide `tick` enable arrives once per second, on the fast system clock. The block counts those ticks and raises `strobe` for exactly one tick interval once every `PERIOD` ticks. With the default `PERIOD` of 3600, that is a one-second strobe once per hour. The counter, the terminal-count decode and the output register all share one clock edge, so both strobe edges land exactly on tick boundaries and the output carries no decode glitches.

Two variants are chosen by `FEEDBACK`:

- **Direct (`FEEDBACK=0`)**: a modulo counter wraps by itself. Its decode passes through one output register.
- **Feedback (`FEEDBACK=1`)**: the decode passes through two registers in series, and the registered strobe clears the counter. The compare value is lowered by the added latency, so the period and the phase match the direct variant.

Top module: `hourly_strobe`

## Requirements
- R1: After the first strobe, successive rising edges of `strobe` are exactly `PERIOD` ticks apart, for any spacing of ticks in clock cycles.
- R2: Each strobe stays high for exactly one tick interval. It rises on one tick and falls on the next tick.
- R3: After reset is released, the first strobe rises on tick number `PERIOD-1`, counting the first tick as 1.
- R4: While `rst` is high, `strobe` is low and the count returns to zero at the next clock edge. This holds even when a strobe was active.
- R5: In clock cycles where `tick` is low, `strobe` and the count keep their values. Only cycles with `tick` high advance the timing.
- R6: With `FEEDBACK=1`, the strobe timing is identical, tick for tick, to that of `FEEDBACK=0`.
- R7: When `rst` and `tick` are both high in the same cycle, reset wins, and that tick is not counted.
- R8: Elaboration fails when `PERIOD` is smaller than the pipeline depth plus 2. The pipeline depth is 1 when `FEEDBACK=0` and 2 when `FEEDBACK=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle enable marking one time-base period |
| strobe | output | 1 | Registered output pulse, one tick wide, once per `PERIOD` ticks |

## Verification
The bench runs both variants side by side over three full periods for each of several tick spacings. It checks the phase of the first strobe, which is where a compare value off by one shows up as a strobe one tick early or late. A design with the wrong counter width or wrong wrap point shows up as a wrong interval between rising edges. A feedback pipeline that was not compensated shows up as a strobe two ticks wide, or as the two variants drifting apart. Idle cycles between ticks expose a design that counts clock cycles instead of ticks. A reset issued in the middle of a strobe, together with a tick, must drop the output and restart the count from zero; a design that lets the tick win would come back one tick early.

// File: rtl/hourly_strobe.sv
`timescale 1ns/1ps
module hourly_strobe #(
  parameter int PERIOD   = 3600,
  parameter bit FEEDBACK = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic strobe
);
  localparam int DEPTH = FEEDBACK ? 2 : 1;
  localparam int W     = (PERIOD > 2) ? $clog2(PERIOD) : 2;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);
  localparam logic [W-1:0] CMP  = W'(PERIOD - 1 - DEPTH);

  logic [W-1:0] cnt;
  logic         hit;

  assign hit = (cnt == CMP);

  if (PERIOD < DEPTH + 2) begin : g_bad_period
    $error("hourly_strobe: PERIOD too small for pipeline depth"); // R8
  end

  if (FEEDBACK) begin : g_feedback
    logic stage1;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt    <= '0;
        stage1 <= 1'b0;
        strobe <= 1'b0;
      end else if (tick) begin
        cnt    <= strobe ? '0 : cnt + 1'b1;
        stage1 <= hit;
        strobe <= stage1;
      end
    end
  end else begin : g_direct
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt    <= '0;
        strobe <= 1'b0;
      end else if (tick) begin
        cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
        strobe <= hit;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R1

  AST_RISE_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> cnt == LAST); // R3

  AST_ONE_TICK_WIDE: assert property (@(posedge clk) disable iff (rst)
    strobe && tick |=> !strobe); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(strobe) && $stable(cnt)); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !strobe && cnt == '0); // R4
endmodule

// File: tb/sim_hourly_strobe.sv
`timescale 1ns/1ps
module sim_hourly_strobe;
  localparam int P = 3600;
  localparam int ROWS = 3;
  localparam int GAP  [ROWS] = '{0, 1, 3};
  localparam int NPER [ROWS] = '{3, 3, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic s0, s1;
  int   tests = 0, fails = 0;

  always #4 clk = ~clk;

  hourly_strobe #(.PERIOD(P), .FEEDBACK(1'b0)) u0 (.clk(clk), .rst(rst), .tick(tick), .strobe(s0));
  hourly_strobe #(.PERIOD(P), .FEEDBACK(1'b1)) u1 (.clk(clk), .rst(rst), .tick(tick), .strobe(s1));

  int n;
  int mism[2], hold_err[2], rises[2], bad_int[2], bad_wid[2], last_rise[2];
  logic prev[2];

  function automatic logic expf(int k);
    return (k >= P - 1) && (((k - (P - 1)) % P) == 0);
  endfunction

  task automatic check(string tag, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic clear_stats();
    n = 0;
    for (int i = 0; i < 2; i++) begin
      mism[i] = 0; hold_err[i] = 0; rises[i] = 0;
      bad_int[i] = 0; bad_wid[i] = 0; last_rise[i] = -1; prev[i] = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tick = 1'b0;
    @(negedge clk); rst = 1'b0;
    clear_stats();
  endtask

  task automatic one_tick(int gap);
    logic cur[2];
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    n++;
    cur[0] = s0; cur[1] = s1;
    for (int i = 0; i < 2; i++) begin
      if (cur[i] !== expf(n)) mism[i]++;
      if (cur[i] && !prev[i]) begin
        if (last_rise[i] >= 0 && n - last_rise[i] != P) bad_int[i]++;
        last_rise[i] = n;
        rises[i]++;
      end
      if (!cur[i] && prev[i] && n - last_rise[i] != 1) bad_wid[i]++;
      prev[i] = cur[i];
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (s0 !== cur[0]) hold_err[0]++;
      if (s1 !== cur[1]) hold_err[1]++;
    end
  endtask

  initial begin
    #1_520_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 reset state direct", int'(s0), 0);
    check("R4 reset state feedback", int'(s1), 0);

    for (int r = 0; r < ROWS; r++) begin
      do_reset();
      for (int t = 0; t < NPER[r] * P; t++) one_tick(GAP[r]);
      check($sformatf("R3 rise count direct gap%0d", GAP[r]), rises[0], NPER[r]);
      check($sformatf("R1 schedule mismatches direct gap%0d", GAP[r]), mism[0], 0);
      check($sformatf("R1 interval errors direct gap%0d", GAP[r]), bad_int[0], 0);
      check($sformatf("R2 width errors direct gap%0d", GAP[r]), bad_wid[0], 0);
      check($sformatf("R5 hold errors direct gap%0d", GAP[r]), hold_err[0], 0);
      check($sformatf("R6 rise count feedback gap%0d", GAP[r]), rises[1], NPER[r]);
      check($sformatf("R6 schedule mismatches feedback gap%0d", GAP[r]), mism[1], 0);
      check($sformatf("R6 interval errors feedback gap%0d", GAP[r]), bad_int[1], 0);
      check($sformatf("R6 width errors feedback gap%0d", GAP[r]), bad_wid[1], 0);
      check($sformatf("R5 hold errors feedback gap%0d", GAP[r]), hold_err[1], 0);
    end

    do_reset();
    for (int t = 0; t < P - 2; t++) one_tick(0);
    check("R3 low before tick PERIOD-1 direct", int'(s0), 0);
    check("R3 low before tick PERIOD-1 feedback", int'(s1), 0);
    one_tick(0);
    check("R3 high at tick PERIOD-1 direct", int'(s0), 1);
    check("R3 high at tick PERIOD-1 feedback", int'(s1), 1);
    repeat (50) @(negedge clk);
    check("R5 strobe held with no ticks direct", int'(s0), 1);
    check("R5 strobe held with no ticks feedback", int'(s1), 1);

    @(negedge clk); rst = 1'b1; tick = 1'b1;
    @(negedge clk); rst = 1'b0; tick = 1'b0;
    check("R4 reset drops strobe direct", int'(s0), 0);
    check("R4 reset drops strobe feedback", int'(s1), 0);
    clear_stats();
    for (int t = 0; t < P - 2; t++) one_tick(0);
    check("R7 tick with reset not counted direct", int'(s0), 0);
    check("R7 tick with reset not counted feedback", int'(s1), 0);
    one_tick(0);
    check("R7 restart phase direct", int'(s0), 1);
    check("R7 restart phase feedback", int'(s1), 1);
    one_tick(0);
    check("R2 falls after one tick direct", int'(s0), 0);
    check("R2 falls after one tick feedback", int'(s1), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule